// File: doc/BRIEF.md
# SYNC-Aligned Timestamp Counter

A 48-bit timestamp counter runs at the 100 MHz system clock and is kept in step with a system-wide SYNC signal. Each rising edge of the SYNC input becomes a one-cycle pulse. That pulse opens a reload window that lasts a fixed number of cycles.

Software can place a new 48-bit value in a staging register, which is written as two halves. Writing either half arms a pending reload. The staged value is copied into the counter only when a second SYNC pulse arrives while the window is still open. A lone SYNC, or a SYNC outside the window, leaves the counter running.

At every SYNC that does not reload, a comparator checks the counter. The expected value is the counter value at the previous SYNC, or the reloaded value, plus the nominal SYNC period. A mismatch sets a sticky error flag, which a control input clears.

Top module: `sync_timestamp`

## Requirements
- R1: After reset the timestamp is 0, and the window, pending-reload and error outputs are low.
- R2: The timestamp increases by exactly one on each clock while `cnt_en_i` is high and no reload occurs. It holds its value while `cnt_en_i` is low.
- R3: `stage_lo_we_i` writes `stage_data_i` into staged bits 31:0. `stage_hi_we_i` writes `stage_data_i[15:0]` into staged bits 47:32. Either write sets `load_pend_o` from the next cycle.
- R4: `sync_pulse_o` is high for exactly one cycle, in the first cycle that `sync_i` is high after being low.
- R5: A SYNC pulse makes `window_o` high for the next `WIN_LEN` cycles. A new pulse restarts that count.
- R6: A SYNC pulse that arrives while `window_o` and `load_pend_o` are both high loads the staged value into the timestamp exactly, without incrementing. It also clears `load_pend_o`, unless a stage write occurs in the same cycle.
- R7: A SYNC pulse outside the window, or with no pending reload, leaves the counting of R2 unchanged and does not clear `load_pend_o`.
- R8: At a SYNC pulse that does not reload, the error flag is set if the timestamp differs from the reference plus `SYNC_PERIOD`. The reference is the timestamp at the previous SYNC pulse, or the staged value if that pulse reloaded. The first SYNC pulse after reset is never compared.
- R9: `sync_err_o` stays high until a cycle with `err_clr_i` high. If the flag is set and cleared in the same cycle, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 100 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable |
| stage_lo_we_i | input | 1 | Write the low 32 staged bits |
| stage_hi_we_i | input | 1 | Write the high 16 staged bits |
| stage_data_i | input | 32 | Staging write data |
| err_clr_i | input | 1 | Clear the sync error flag |
| sync_i | input | 1 | System SYNC level |
| ts_o | output | 48 | Timestamp |
| sync_pulse_o | output | 1 | One-cycle SYNC detect pulse |
| window_o | output | 1 | Reload window open |
| load_pend_o | output | 1 | Reload armed |
| sync_err_o | output | 1 | Sticky sync mismatch flag |

## Verification
The hardest case to reach is a reload. It needs a stage write, then a SYNC rising edge, then a second rising edge only a few cycles later. The sequence is run with the second edge placed at every distance from just inside the window to just past its end. It is run both with and without a pending write, and once with a stage write in the very cycle of the reloading SYNC. The comparator is exercised separately by trains of SYNC edges whose spacing is on, one short of and one past the nominal period, with the count enable dropped between edges.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int unsigned TS_W_DEF = 48;
  localparam int unsigned LO_W_DEF = 32;
endpackage

// File: rtl/ts_sync_det.sv
module ts_sync_det #(
  parameter int unsigned WIN_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic pulse_o,
  output logic window_o
);
  localparam int unsigned CW = $clog2(WIN_LEN + 1);

  logic          sync_d;
  logic [CW-1:0] win_cnt;

  assign pulse_o  = sync_i & ~sync_d;
  assign window_o = (win_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_d  <= 1'b0;
      win_cnt <= '0;
    end else begin
      sync_d <= sync_i;
      if (pulse_o)       win_cnt <= CW'(WIN_LEN);
      else if (window_o) win_cnt <= win_cnt - 1'b1;
    end
  end

  // R4
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  // R5
  window_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> window_o);
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int unsigned TS_W = ts_pkg::TS_W_DEF,
  parameter int unsigned LO_W = ts_pkg::LO_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cnt_en_i,
  input  logic            lo_we_i,
  input  logic            hi_we_i,
  input  logic [LO_W-1:0] wdata_i,
  input  logic            reload_i,
  output logic [TS_W-1:0] ts_o,
  output logic [TS_W-1:0] stage_o,
  output logic            pend_o
);
  localparam int unsigned HI_W = TS_W - LO_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_o    <= '0;
      stage_o <= '0;
      pend_o  <= 1'b0;
    end else begin
      if (reload_i)      ts_o <= stage_o;
      else if (cnt_en_i) ts_o <= ts_o + 1'b1;
      if (lo_we_i) stage_o[LO_W-1:0]    <= wdata_i;
      if (hi_we_i) stage_o[TS_W-1:LO_W] <= wdata_i[HI_W-1:0];
      if (lo_we_i || hi_we_i) pend_o <= 1'b1;
      else if (reload_i)      pend_o <= 1'b0;
    end
  end

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !reload_i) |=> ts_o == $past(ts_o) + 1'b1);
  // R2
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !reload_i) |=> $stable(ts_o));
  // R6
  reload_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> ts_o == $past(stage_o));
  // R6
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && !lo_we_i && !hi_we_i) |=> !pend_o);
endmodule

// File: rtl/ts_sync_cmp.sv
module ts_sync_cmp #(
  parameter int unsigned TS_W        = ts_pkg::TS_W_DEF,
  parameter int unsigned SYNC_PERIOD = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pulse_i,
  input  logic            reload_i,
  input  logic [TS_W-1:0] ts_i,
  input  logic [TS_W-1:0] stage_i,
  input  logic            clr_i,
  output logic            err_o
);
  logic [TS_W-1:0] ref_q;
  logic            ref_vld;
  logic            miss;

  assign miss = pulse_i && !reload_i && ref_vld &&
                (ts_i != ref_q + TS_W'(SYNC_PERIOD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= '0;
      ref_vld <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      if (pulse_i) begin
        ref_q   <= reload_i ? stage_i : ts_i;
        ref_vld <= 1'b1;
      end
      if (miss)       err_o <= 1'b1;
      else if (clr_i) err_o <= 1'b0;
    end
  end

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);
  // R9
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !pulse_i) |=> !err_o);
endmodule

// File: rtl/sync_timestamp.sv
module sync_timestamp #(
  parameter int unsigned TS_W        = ts_pkg::TS_W_DEF,
  parameter int unsigned LO_W        = ts_pkg::LO_W_DEF,
  parameter int unsigned WIN_LEN     = 16,
  parameter int unsigned SYNC_PERIOD = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cnt_en_i,
  input  logic            stage_lo_we_i,
  input  logic            stage_hi_we_i,
  input  logic [LO_W-1:0] stage_data_i,
  input  logic            err_clr_i,
  input  logic            sync_i,
  output logic [TS_W-1:0] ts_o,
  output logic            sync_pulse_o,
  output logic            window_o,
  output logic            load_pend_o,
  output logic            sync_err_o
);
  logic            reload;
  logic [TS_W-1:0] stage;

  assign reload = sync_pulse_o & window_o & load_pend_o;

  ts_sync_det #(.WIN_LEN(WIN_LEN)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i),
    .pulse_o(sync_pulse_o), .window_o(window_o)
  );

  ts_counter #(.TS_W(TS_W), .LO_W(LO_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i),
    .lo_we_i(stage_lo_we_i), .hi_we_i(stage_hi_we_i), .wdata_i(stage_data_i),
    .reload_i(reload), .ts_o(ts_o), .stage_o(stage), .pend_o(load_pend_o)
  );

  ts_sync_cmp #(.TS_W(TS_W), .SYNC_PERIOD(SYNC_PERIOD)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(sync_pulse_o), .reload_i(reload),
    .ts_i(ts_o), .stage_i(stage), .clr_i(err_clr_i), .err_o(sync_err_o)
  );

  // R7
  no_reload_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_pulse_o && !window_o && !stage_lo_we_i && !stage_hi_we_i && load_pend_o)
    |=> load_pend_o);
endmodule

// File: tb/sim_sync_timestamp.sv
`timescale 1ns/1ps
module sim_sync_timestamp;
  localparam int W   = 4;
  localparam int PER = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, lo_we = 1'b0, hi_we = 1'b0, clr = 1'b0, sync = 1'b0;
  logic [31:0] wd = '0;
  logic [47:0] ts;
  logic        pulse, win, pend, err;

  always #5 clk = ~clk;

  sync_timestamp #(.WIN_LEN(W), .SYNC_PERIOD(PER)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .stage_lo_we_i(lo_we),
    .stage_hi_we_i(hi_we), .stage_data_i(wd), .err_clr_i(clr), .sync_i(sync),
    .ts_o(ts), .sync_pulse_o(pulse), .window_o(win), .load_pend_o(pend),
    .sync_err_o(err)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model built from the requirements
  logic [47:0] m_ts, m_stage, m_ref;
  logic        m_pend, m_err, m_rv, m_sd;
  int          m_win;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ts = '0; m_stage = '0; m_ref = '0;
      m_pend = 0; m_err = 0; m_rv = 0; m_sd = 0; m_win = 0;
    end else begin
      logic p, rl;
      p  = sync && !m_sd;
      rl = p && (m_win != 0) && m_pend;
      if (p && !rl && m_rv && m_ts != m_ref + 48'(PER)) m_err = 1;
      else if (clr) m_err = 0;
      if (p) begin m_ref = rl ? m_stage : m_ts; m_rv = 1; end
      if (rl) m_ts = m_stage;
      else if (en) m_ts = m_ts + 1;
      if (lo_we || hi_we) m_pend = 1;
      else if (rl) m_pend = 0;
      if (lo_we) m_stage[31:0] = wd;
      if (hi_we) m_stage[47:32] = wd[15:0];
      if (p) m_win = W;
      else if (m_win != 0) m_win = m_win - 1;
      m_sd = sync;
    end
  end

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 R6 R7 ts", ts, m_ts);
    chk("R5 window", 48'(win), 48'(m_win != 0));
    chk("R3 R6 pend", 48'(pend), 48'(m_pend));
    chk("R8 R9 err", 48'(err), 48'(m_err));
  endtask

  // set inputs, check the pulse, then advance one clock and check state
  task automatic cyc(input logic s, input logic e, input logic l, input logic h,
                     input logic [31:0] d, input logic c);
    sync = s; en = e; lo_we = l; hi_we = h; wd = d; clr = c;
    #1;
    chk("R4 pulse", 48'(pulse), 48'(s && !m_sd));
    @(posedge clk); #1;
    check_all();
  endtask

  task automatic idle(input int n, input logic e);
    for (int i = 0; i < n; i++) cyc(0, e, 0, 0, '0, 0);
  endtask

  task automatic edge_sync(input logic e);
    cyc(1, e, 0, 0, '0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #12;
    // R1 reset state
    chk("R1 ts", ts, 48'h0);
    chk("R1 flags", 48'({win, pend, err}), 48'h0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    // R2 counting and hold
    idle(5, 1); idle(3, 0); idle(4, 1);
    // R8 sync trains with spacing on, short of and past the period
    foreach (PERIODS[k]) begin
      edge_sync(1);
      idle(PERIODS[k] - 1, 1);
    end
    edge_sync(1);
    idle(3, 1);
    // R9 clear, and set-wins when clear coincides with a mismatching sync
    cyc(0, 1, 0, 0, '0, 1);
    idle(PER - 4, 1);
    cyc(1, 1, 0, 0, '0, 1);
    idle(4, 1);
    cyc(0, 1, 0, 0, '0, 1);
    // R8 period with count enable dropped between edges
    edge_sync(1); idle(5, 1); idle(2, 0); idle(PER - 8, 1);
    edge_sync(1); idle(2, 1);
    // R6 R7 second edge at every offset, with and without pending write
    for (int off = 2; off <= W + 3; off++) begin
      for (int wr = 0; wr < 2; wr++) begin
        cyc(0, 1, 0, 0, '0, 1);
        if (wr != 0) begin
          cyc(0, 1, 1, 0, 32'hA5000000 + 32'(off), 0);
          cyc(0, 1, 0, 1, 32'h0000C300 + 32'(off), 0);
        end
        edge_sync(1);
        idle(off - 1, 1);
        edge_sync(1);
        idle(W + 2, 1);
        // R7 lone sync with pending still armed from a late edge
        edge_sync(1);
        idle(W + 2, 1);
      end
    end
    // R3 R6 stage write coincident with the reloading sync keeps pending
    cyc(0, 1, 1, 1, 32'h12345678, 0);
    edge_sync(1); idle(1, 1);
    cyc(1, 0, 1, 0, 32'hDEAD0001, 0);
    idle(3, 0);
    edge_sync(1); idle(2, 1);
    edge_sync(1); idle(W + 2, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam int PERIODS [5] = '{PER, PER, PER - 1, PER, PER + 1};
endmodule